// File: doc/BRIEF.md
# Vectored Interrupt Controller with GPIO Edge Detection

This block collects seven interrupt sources and presents one request and one vector address to a small CPU. Six sources arrive as one-cycle pulses: bus reset, a 128 µs tick, a 1.024 ms tick, endpoint 0, endpoint 1 and wake-up. The seventh is formed inside the block from a ten-pin GPIO port pair. Each pin has its own enable bit and its own edge-polarity bit, and any enabled pin that sees its selected edge raises the single GPIO source.

Every source latches into a pending bit. A source mask register decides which pending bits may raise a request, and the CPU's own interrupt-enable flag gates the result. When the CPU acknowledges, the block returns the vector of the pending, unmasked source with the lowest vector address. It clears that one pending bit and pulses an output that tells the CPU to drop its interrupt-enable flag. Vector addresses are even, and the reserved gap from 0x000C to 0x0012 is never issued.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, all control registers (pin enables, pin polarities, source mask) and all pending bits are zero, so `irqReq` and `intEnClr` are low.
- R2: A source pulse sets its pending bit. The bit is kept while its mask bit is 0, and it raises a request as soon as the mask bit is written to 1.
- R3: `irqReq` is high only while `cpuIntEn` is 1 and at least one pending source has its mask bit set.
- R4: When several enabled sources are pending, `vecAddr` names the one with the lowest vector address.
- R5: Vector addresses are bus reset 0x0002, 128 µs tick 0x0004, 1.024 ms tick 0x0006, endpoint 0 0x0008, endpoint 1 0x000A, GPIO 0x0014, wake-up 0x0016. Addresses 0x000C to 0x0012 are never driven while `irqReq` is high. `srcPulse` bits 0..5 are bus reset, 128 µs, 1.024 ms, endpoint 0, endpoint 1, wake-up.
- R6: An acknowledge (`irqAck` high while `irqReq` is high) raises `intEnClr` in the same cycle and clears only the pending bit of the served source at that clock edge.
- R7: A pin whose enable bit is 1 and whose polarity bit is 1 raises the GPIO source on a rising edge and not on a falling edge.
- R8: A pin whose enable bit is 1 and whose polarity bit is 0 raises the GPIO source on a falling edge and not on a rising edge.
- R9: A pin whose enable bit is 0 has no effect on the GPIO source. Port-1 pins (`gpioPins[9:8]`) use bits [1:0] of their enable and polarity registers.
- R10: If a source pulses in the same cycle that its own vector is acknowledged, its pending bit stays set.
- R11: Register addresses are 0x04 port-0 pin enable, 0x05 port-1 pin enable, 0x06 port-0 polarity, 0x07 port-1 polarity, and 0x20 source mask. In the source mask, bits 0..6 follow vector order: bus reset, 128 µs, 1.024 ms, endpoint 0, endpoint 1, GPIO, wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register write address |
| regWrData | input | 8 | Register write data |
| srcPulse | input | 6 | One-cycle source events: bus reset, 128 µs, 1.024 ms, EP0, EP1, wake-up |
| gpioPins | input | 10 | Raw GPIO pins; bits 7:0 form port 0, bits 9:8 form port 1 |
| cpuIntEn | input | 1 | CPU interrupt-enable flag |
| irqAck | input | 1 | CPU acknowledge of the current request |
| irqReq | output | 1 | Interrupt request to the CPU |
| vecAddr | output | 14 | Vector address of the source to be served |
| intEnClr | output | 1 | Pulse telling the CPU to clear its interrupt-enable flag |

## Verification
The bench drives each pulse source alone to pin down every vector address. It then drives several sources at once and acknowledges them one by one, which separates priority order from single-bit clearing. GPIO pins are toggled in both directions under both polarities and with the enable bit off, on a port-0 pin and on a port-1 pin. This shows that edge selection, per-pin gating and the port-1 register lanes are independent of each other. Masked-then-unmasked sources, a low CPU flag, and a pulse that coincides with its own acknowledge each test one gating or retention rule that the basic flow never reaches.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_SRC   = 7;
  localparam int SRC_IDX_W = $clog2(NUM_SRC);
  localparam int VEC_W     = 14;
  localparam int GPIO_IDX  = 5;
  localparam int WAKE_IDX  = 6;
  localparam int GAP_BASE  = 'h14;

  localparam logic [7:0] ADDR_EN_LO  = 8'h04;
  localparam logic [7:0] ADDR_EN_HI  = 8'h05;
  localparam logic [7:0] ADDR_POL_LO = 8'h06;
  localparam logic [7:0] ADDR_POL_HI = 8'h07;
  localparam logic [7:0] ADDR_MASK   = 8'h20;

  typedef struct packed {
    logic wrEnLo;
    logic wrEnHi;
    logic wrPolLo;
    logic wrPolHi;
    logic wrMask;
    logic ackFire;
  } vicStrobes_t;

  // Sources below GPIO sit back to back from 0x0002; GPIO and above skip the reserved gap.
  function automatic logic [VEC_W-1:0] vecOf(input logic [SRC_IDX_W-1:0] idx);
    if (int'(idx) < GPIO_IDX) return VEC_W'(2 * (int'(idx) + 1));
    else return VEC_W'(GAP_BASE + 2 * (int'(idx) - GPIO_IDX));
  endfunction
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic        cpuIntEn,
  input  logic        irqAck,
  input  logic        anyEnabled,
  output vicStrobes_t strobes,
  output logic        irqReq,
  output logic        intEnClr
);
  always_comb begin
    irqReq           = cpuIntEn & anyEnabled;
    strobes.wrEnLo   = regWrEn && (regAddr == ADDR_EN_LO);
    strobes.wrEnHi   = regWrEn && (regAddr == ADDR_EN_HI);
    strobes.wrPolLo  = regWrEn && (regAddr == ADDR_POL_LO);
    strobes.wrPolHi  = regWrEn && (regAddr == ADDR_POL_HI);
    strobes.wrMask   = regWrEn && (regAddr == ADDR_MASK);
    strobes.ackFire  = irqAck & irqReq;
    intEnClr         = strobes.ackFire;
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int P0_W = 8,
  parameter int P1_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  vicStrobes_t            strobes,
  input  logic [7:0]             regWrData,
  input  logic [NUM_SRC-2:0]     srcPulse,
  input  logic [P0_W+P1_W-1:0]   gpioPins,
  output logic                   anyEnabled,
  output logic [VEC_W-1:0]       vecAddr,
  output logic [NUM_SRC-1:0]     pendBits
);
  localparam int GPIO_W = P0_W + P1_W;

  logic [GPIO_W-1:0]  pinEn, pinPol, pinPrev;
  logic [GPIO_W-1:0]  syncStage [SYNC_STAGES];
  logic [GPIO_W-1:0]  pinHit;
  logic [NUM_SRC-1:0] srcMask, activeVec, setVec, clrVec;
  logic [SRC_IDX_W-1:0] servedIdx;

  // Control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pinEn   <= '0;
      pinPol  <= '0;
      srcMask <= '0;
    end else begin
      if (strobes.wrEnLo)  pinEn[P0_W-1:0]       <= regWrData[P0_W-1:0];
      if (strobes.wrEnHi)  pinEn[GPIO_W-1:P0_W]  <= regWrData[P1_W-1:0];
      if (strobes.wrPolLo) pinPol[P0_W-1:0]      <= regWrData[P0_W-1:0];
      if (strobes.wrPolHi) pinPol[GPIO_W-1:P0_W] <= regWrData[P1_W-1:0];
      if (strobes.wrMask)  srcMask               <= regWrData[NUM_SRC-1:0];
    end
  end

  // Pin synchroniser chain and previous-sample register
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= gpioPins;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) pinPrev <= '0;
    else pinPrev <= syncStage[SYNC_STAGES-1];
  end

  // Per-pin edge select: polarity 1 = rising, 0 = falling
  generate
    for (genvar p = 0; p < GPIO_W; p++) begin : g_edge
      always_comb begin
        if (pinPol[p]) pinHit[p] = pinEn[p] &  syncStage[SYNC_STAGES-1][p] & ~pinPrev[p];
        else           pinHit[p] = pinEn[p] & ~syncStage[SYNC_STAGES-1][p] &  pinPrev[p];
      end
    end
  endgenerate

  // Pending set/clear; a new event wins over a same-cycle clear
  always_comb begin
    setVec = {srcPulse[NUM_SRC-2], |pinHit, srcPulse[GPIO_IDX-1:0]};
    clrVec = '0;
    if (strobes.ackFire) clrVec[servedIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pendBits <= '0;
    else pendBits <= (pendBits & ~clrVec) | setVec;
  end

  // Lowest index (lowest vector) wins
  always_comb begin
    activeVec  = pendBits & srcMask;
    anyEnabled = |activeVec;
    servedIdx  = '0;
    for (int i = NUM_SRC-1; i >= 0; i--) begin
      if (activeVec[i]) servedIdx = SRC_IDX_W'(i);
    end
    vecAddr = vecOf(servedIdx);
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int P0_W = 8,
  parameter int P1_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 regWrEn,
  input  logic [7:0]           regAddr,
  input  logic [7:0]           regWrData,
  input  logic [NUM_SRC-2:0]   srcPulse,
  input  logic [P0_W+P1_W-1:0] gpioPins,
  input  logic                 cpuIntEn,
  input  logic                 irqAck,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     vecAddr,
  output logic                 intEnClr
);
  vicStrobes_t        strobes;
  logic               anyEnabled;
  logic [NUM_SRC-1:0] pendBits;

  vic_ctrl ctrl_i (
    .regWrEn(regWrEn), .regAddr(regAddr), .cpuIntEn(cpuIntEn), .irqAck(irqAck),
    .anyEnabled(anyEnabled), .strobes(strobes), .irqReq(irqReq), .intEnClr(intEnClr)
  );

  vic_datapath #(.P0_W(P0_W), .P1_W(P1_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .regWrData(regWrData),
    .srcPulse(srcPulse), .gpioPins(gpioPins), .anyEnabled(anyEnabled),
    .vecAddr(vecAddr), .pendBits(pendBits)
  );
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk
  import vic_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cpuIntEn,
  input logic               irqAck,
  input logic               irqReq,
  input logic               intEnClr,
  input logic [VEC_W-1:0]   vecAddr,
  input logic [NUM_SRC-1:0] pendBits
);
  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> cpuIntEn);

  // R5
  rsvd_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (!vecAddr[0] && !(vecAddr >= VEC_W'('h0C) && vecAddr <= VEC_W'('h12))));

  // R2
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !intEnClr |=> (($past(pendBits) & ~pendBits) == '0));

  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intEnClr |=> ($countones($past(pendBits) & ~pendBits) <= 1));

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intEnClr |-> (irqAck && irqReq));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irqReq && !intEnClr));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpuIntEn(cpuIntEn), .irqAck(irqAck), .irqReq(irqReq),
  .intEnClr(intEnClr), .vecAddr(vecAddr), .pendBits(pendBits)
);

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [5:0]  srcPulse = '0;
  logic [9:0]  gpioPins = '0;
  logic        cpuIntEn = 1'b0;
  logic        irqAck = 1'b0;
  logic        irqReq;
  logic [13:0] vecAddr;
  logic        intEnClr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .srcPulse(srcPulse), .gpioPins(gpioPins), .cpuIntEn(cpuIntEn), .irqAck(irqAck),
    .irqReq(irqReq), .vecAddr(vecAddr), .intEnClr(intEnClr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
    #1;
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk); srcPulse = p;
    @(negedge clk); srcPulse = '0;
    #1;
  endtask

  task automatic ack(input string req, input logic [5:0] p);
    @(negedge clk); irqAck = 1; srcPulse = p; #1;
    chk({req, " intEnClr"}, 16'(intEnClr), 16'd1);
    @(negedge clk); irqAck = 0; srcPulse = '0; #1;
  endtask

  task automatic setPins(input logic [9:0] v);
    @(negedge clk); gpioPins = v;
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic expReq(input string req, input logic r, input logic [13:0] v);
    chk({req, " irqReq"}, 16'(irqReq), 16'(r));
    if (r) chk({req, " vecAddr"}, 16'(vecAddr), 16'(v));
  endtask

  task automatic t_reset();
    #1;
    chk("R1 irqReq", 16'(irqReq), 16'd0);
    chk("R1 intEnClr", 16'(intEnClr), 16'd0);
    cpuIntEn = 1;
    #1;
    chk("R1 mask clear", 16'(irqReq), 16'd0);
  endtask

  task automatic t_maskRetain();
    pulse(6'b001000);
    expReq("R2 masked", 0, 0);
    repeat (3) @(negedge clk);
    wrReg(8'h20, 8'h08);
    expReq("R2 R11 unmask ep0", 1, 14'h0008);
    ack("R6 ep0", 0);
    expReq("R6 cleared", 0, 0);
  endtask

  task automatic t_gate();
    wrReg(8'h20, 8'h02);
    cpuIntEn = 0;
    pulse(6'b000010);
    expReq("R3 flag low", 0, 0);
    cpuIntEn = 1; #1;
    expReq("R3 flag high", 1, 14'h0004);
    ack("R3", 0);
  endtask

  task automatic t_vecTable();
    logic [13:0] expV [6] = '{14'h2, 14'h4, 14'h6, 14'h8, 14'hA, 14'h16};
    wrReg(8'h20, 8'h7F);
    for (int i = 0; i < 6; i++) begin
      pulse(6'(1 << i));
      expReq("R5 table", 1, expV[i]);
      ack("R5", 0);
      expReq("R5 after ack", 0, 0);
    end
  endtask

  task automatic t_priority();
    pulse(6'b110001);
    expReq("R4 first", 1, 14'h0002);
    ack("R4", 0);
    expReq("R4 R6 second", 1, 14'h000A);
    ack("R4", 0);
    expReq("R4 third", 1, 14'h0016);
    ack("R4", 0);
    expReq("R6 all served", 0, 0);
  endtask

  task automatic t_gpioRise();
    wrReg(8'h06, 8'h01);
    wrReg(8'h04, 8'h01);
    setPins(10'h001);
    expReq("R7 rise", 1, 14'h0014);
    ack("R7", 0);
    setPins(10'h000);
    expReq("R7 fall ignored", 0, 0);
  endtask

  task automatic t_gpioFall();
    wrReg(8'h06, 8'h00);
    wrReg(8'h04, 8'h08);
    setPins(10'h008);
    expReq("R8 rise ignored", 0, 0);
    setPins(10'h000);
    expReq("R8 fall", 1, 14'h0014);
    ack("R8", 0);
  endtask

  task automatic t_gpioPort1();
    wrReg(8'h04, 8'h00);
    setPins(10'h004);
    setPins(10'h000);
    expReq("R9 disabled pin", 0, 0);
    wrReg(8'h07, 8'h02);
    wrReg(8'h05, 8'h02);
    setPins(10'h100);
    expReq("R9 other port1 pin", 0, 0);
    setPins(10'h200);
    expReq("R9 R11 port1 rise", 1, 14'h0014);
    ack("R9", 0);
    expReq("R9 cleared", 0, 0);
  endtask

  task automatic t_setWins();
    pulse(6'b010000);
    expReq("R10 ep1", 1, 14'h000A);
    ack("R10", 6'b010000);
    expReq("R10 kept", 1, 14'h000A);
    ack("R10", 0);
    expReq("R10 cleared", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_maskRetain();
    t_gate();
    t_vecTable();
    t_priority();
    t_gpioRise();
    t_gpioFall();
    t_gpioPort1();
    t_setWins();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule